// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

This block is a memory-mapped asynchronous serial transmitter and receiver using NRZ line coding. Software sets the bit rate with a divisor, chooses the character length (1 to 32 bits), the parity mode and the stop-bit length, and then moves characters through two 16-entry FIFOs behind a data register for each direction. Characters leave and arrive least significant bit first. An idle line is high.

A status register reports how full both FIFOs are. It also holds sticky line-error flags and a receive-level threshold flag. A level interrupt output is asserted whenever any status bit that has its enable bit set is active. The transmitter can wait a programmed number of oversampling ticks before a character starts. The receiver ignores short pulses on its input: an input-qualification count sets how long a new level must be held before the receiver accepts it.

The register port is a single-cycle interface. Writes take effect at the clock edge. Read data is combinational from the address. A read of the receive register, or of the status register, has its side effect at the clock edge that ends the read cycle.

Top module: `sio_uart`

## Requirements
- R1: After reset, `txd` is high, `irq` is low, and the status register (offset 0x0C) reads 0x001. Only bit 0, transmit FIFO empty, is set, because the receive threshold resets to 0 and the receive FIFO is empty.
- R2: The divisor register (offset 0x00, 16 bits) sets the oversampling tick period in clock cycles. Every transmitted bit lasts 16 ticks.
- R3: A frame is one low start bit, then the data bits LSB first, then an optional parity bit, then high stop time. The number of data bits comes from control bits [10:5] (control at offset 0x14). A value of 0 is treated as 1 and values above 32 are treated as 32. On transmit, data bits above the length are dropped.
- R4: Control bits [4:3] select parity: 01 odd, 10 even, 00 or 11 none. The receiver sets status bit 4 (parity error) when the received parity bit does not match.
- R5: Control bits [2:1] select the stop time: 00 gives 16 ticks, 01 gives 24 ticks, and 10 or 11 gives 32 ticks.
- R6: The delay register (offset 0x10, 8 bits) holds a count D. The transmitter waits D ticks after taking a character from its FIFO before it drives the start bit.
- R7: The receiver starts on a qualified falling edge and confirms the start bit 8 ticks later. It samples each later bit every 16 ticks and writes the character into a 16-entry FIFO. A read of offset 0x08 returns the oldest character and removes it; an empty FIFO reads 0. Status bit 2 means the receive FIFO is not empty and bit 3 means it is full.
- R8: Status bit 6 (frame error) is set when the sampled stop bit is 0. Status bit 7 (break) is set when the stop bit and all data bits are 0. Status bit 5 (overrun) is set when a character completes while the receive FIFO is full; that character is dropped. Bits 4 to 7 stay set until the status register is read.
- R9: A change on `rxd` reaches the receiver only after it has held for more than IQ cycles. IQ is the 8-bit value at offset 0x1C. A shorter pulse is ignored.
- R10: Status bit 8 is set while the receive FIFO level is greater than the 8-bit threshold at offset 0x20.
- R11: `irq` is high exactly when some status bit i is 1 and enable bit i is also 1. The enable register is at offset 0x18 and has bits 0 to 8.
- R12: The transmit FIFO holds 16 entries and is written at offset 0x04. Status bit 0 means it is empty and bit 1 means it is full. A write while it is full is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers pop or flag clear) |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that software does not change the character length, parity or stop setting while a frame is in flight. The stimulus respects this by reconfiguring only after both shifters have gone idle and the line has been high for at least one bit. They also assume that `rd_en` and `wr_en` are never asserted in the same cycle. The bench drives the strobes from one task at a time, so this always holds. The bench drives every serial input frame with whole bit times at the programmed divisor. Short pulses appear only in the test that targets the input qualifier.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int MAX_LEN = 32;

    localparam logic [5:0] A_DIV  = 6'h00;
    localparam logic [5:0] A_TX   = 6'h04;
    localparam logic [5:0] A_RX   = 6'h08;
    localparam logic [5:0] A_STAT = 6'h0C;
    localparam logic [5:0] A_DLY  = 6'h10;
    localparam logic [5:0] A_CTRL = 6'h14;
    localparam logic [5:0] A_IEN  = 6'h18;
    localparam logic [5:0] A_IQ   = 6'h1C;
    localparam logic [5:0] A_THR  = 6'h20;

    // sticky error bits as held in the error vector
    localparam int E_PAR = 0;
    localparam int E_OVR = 1;
    localparam int E_FRM = 2;
    localparam int E_BRK = 3;

    typedef enum logic [1:0] {PAR_NONE = 2'b00, PAR_ODD = 2'b01, PAR_EVEN = 2'b10, PAR_RSVD = 2'b11} par_e;

    typedef struct packed {
        logic [5:0] len;
        logic [1:0] par;
        logic [1:0] stop;
    } line_cfg_t;

    typedef enum logic [2:0] {TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

    function automatic logic [5:0] eff_len(input logic [5:0] l);
        if (l == 6'd0) return 6'd1;
        if (l > 6'd32) return 6'd32;
        return l;
    endfunction

    function automatic logic [31:0] len_mask(input logic [5:0] l);
        logic [32:0] m;
        m = (33'd1 << l) - 33'd1;
        return m[31:0];
    endfunction

    function automatic logic par_on(input logic [1:0] p);
        return (p == PAR_ODD) || (p == PAR_EVEN);
    endfunction

    function automatic logic par_bit(input logic [1:0] p, input logic [31:0] d);
        return (p == PAR_ODD) ? ~^d : ^d;
    endfunction

    function automatic logic [5:0] stop_ticks(input logic [1:0] s);
        case (s)
            2'b00:   return 6'd16;
            2'b01:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign dout  = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  line_cfg_t   cfg,
    input  logic [7:0]  dly,
    input  logic        empty,
    input  logic [31:0] din,
    output logic        pop,
    output logic        txd,
    output logic        idle
);
    typedef struct packed {
        tx_st_e      st;
        logic [5:0]  tcnt;
        logic [5:0]  bcnt;
        logic [31:0] sh;
        logic        pbit;
        logic [7:0]  dcnt;
        logic        txd;
    } tx_t;

    tx_t        q, d;
    logic [5:0] len;
    logic [31:0] masked;

    assign len    = eff_len(cfg.len);
    assign masked = din & len_mask(len);
    assign txd    = q.txd;
    assign idle   = (q.st == TX_IDLE);

    always_comb begin
        d   = q;
        pop = 1'b0;
        case (q.st)
            TX_IDLE: begin
                d.txd = 1'b1;
                if (!empty) begin
                    pop    = 1'b1;
                    d.sh   = masked;
                    d.pbit = par_bit(cfg.par, masked);
                    d.tcnt = '0;
                    d.bcnt = '0;
                    if (dly == 8'd0) begin
                        d.st  = TX_START;
                        d.txd = 1'b0;
                    end else begin
                        d.st   = TX_WAIT;
                        d.dcnt = dly;
                    end
                end
            end
            TX_WAIT: if (tick) begin
                if (q.dcnt == 8'd1) begin
                    d.st  = TX_START;
                    d.txd = 1'b0;
                end else begin
                    d.dcnt = q.dcnt - 8'd1;
                end
            end
            TX_START: if (tick) begin
                if (q.tcnt == 6'd15) begin
                    d.tcnt = '0;
                    d.st   = TX_DATA;
                    d.txd  = q.sh[0];
                end else d.tcnt = q.tcnt + 6'd1;
            end
            TX_DATA: if (tick) begin
                if (q.tcnt == 6'd15) begin
                    d.tcnt = '0;
                    d.sh   = q.sh >> 1;
                    if (q.bcnt == len - 6'd1) begin
                        if (par_on(cfg.par)) begin
                            d.st  = TX_PAR;
                            d.txd = q.pbit;
                        end else begin
                            d.st  = TX_STOP;
                            d.txd = 1'b1;
                        end
                    end else begin
                        d.bcnt = q.bcnt + 6'd1;
                        d.txd  = q.sh[1];
                    end
                end else d.tcnt = q.tcnt + 6'd1;
            end
            TX_PAR: if (tick) begin
                if (q.tcnt == 6'd15) begin
                    d.tcnt = '0;
                    d.st   = TX_STOP;
                    d.txd  = 1'b1;
                end else d.tcnt = q.tcnt + 6'd1;
            end
            TX_STOP: if (tick) begin
                if (q.tcnt == stop_ticks(cfg.stop) - 6'd1) begin
                    d.tcnt = '0;
                    d.st   = TX_IDLE;
                    d.txd  = 1'b1;
                end else d.tcnt = q.tcnt + 6'd1;
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= TX_IDLE;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  line_cfg_t   cfg,
    input  logic [7:0]  iq,
    input  logic        rxd,
    output logic        push,
    output logic [31:0] data,
    output logic        perr,
    output logic        ferr,
    output logic        berr
);
    typedef struct packed {
        logic        s1;
        logic        s2;
        logic        lvl;
        logic        lvl_p;
        logic [7:0]  qcnt;
        rx_st_e      st;
        logic [4:0]  tcnt;
        logic [5:0]  bcnt;
        logic [31:0] sh;
        logic        pbit;
    } rx_t;

    rx_t        q, d;
    logic [5:0] len;

    assign len  = eff_len(cfg.len);
    assign data = q.sh >> (6'd32 - len);
    assign perr = par_on(cfg.par) && (q.pbit != par_bit(cfg.par, data));
    assign ferr = !q.lvl;
    assign berr = !q.lvl && (data == '0);

    always_comb begin
        d       = q;
        push    = 1'b0;
        d.s1    = rxd;
        d.s2    = q.s1;
        d.lvl_p = q.lvl;
        // input qualification: a new level must persist beyond iq cycles
        if (q.s2 != q.lvl) begin
            if (q.qcnt >= iq) begin
                d.lvl  = q.s2;
                d.qcnt = '0;
            end else d.qcnt = q.qcnt + 8'd1;
        end else d.qcnt = '0;

        case (q.st)
            RX_IDLE: if (q.lvl_p && !q.lvl) begin
                d.st   = RX_START;
                d.tcnt = '0;
            end
            RX_START: if (tick) begin
                if (q.tcnt == 5'd7) begin
                    d.tcnt = '0;
                    d.bcnt = '0;
                    d.st   = q.lvl ? RX_IDLE : RX_DATA;
                end else d.tcnt = q.tcnt + 5'd1;
            end
            RX_DATA: if (tick) begin
                if (q.tcnt == 5'd15) begin
                    d.tcnt = '0;
                    d.sh   = {q.lvl, q.sh[31:1]};
                    if (q.bcnt == len - 6'd1) d.st = par_on(cfg.par) ? RX_PAR : RX_STOP;
                    else                      d.bcnt = q.bcnt + 6'd1;
                end else d.tcnt = q.tcnt + 5'd1;
            end
            RX_PAR: if (tick) begin
                if (q.tcnt == 5'd15) begin
                    d.tcnt = '0;
                    d.pbit = q.lvl;
                    d.st   = RX_STOP;
                end else d.tcnt = q.tcnt + 5'd1;
            end
            RX_STOP: if (tick) begin
                if (q.tcnt == 5'd15) begin
                    d.tcnt = '0;
                    push   = 1'b1;
                    d.st   = RX_IDLE;
                end else d.tcnt = q.tcnt + 5'd1;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= RX_IDLE;
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.lvl   <= 1'b1;
            q.lvl_p <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sio_uart.sv
module sio_uart
    import sio_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [5:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        txd,
    input  logic        rxd,
    output logic        irq
);
    typedef struct packed {
        logic [15:0] div;
        line_cfg_t   cfg;
        logic [8:0]  ien;
        logic [7:0]  dly;
        logic [7:0]  iq;
        logic [7:0]  thr;
        logic [3:0]  err;
        logic [15:0] bcnt;
        logic        tick;
    } top_t;

    top_t q, d;

    logic          tx_wr, tx_pop, tx_full, tx_empty, tx_idle;
    logic [31:0]   tx_dout;
    logic [CW-1:0] tx_cnt;
    logic          rx_pop, rx_push, rx_full, rx_empty;
    logic [31:0]   rx_dout, rx_data;
    logic [CW-1:0] rx_cnt;
    logic          rx_perr, rx_ferr, rx_berr;
    logic          stat_rd, thr_hit, ovr_flag;
    logic [8:0]    status, ien;
    logic [15:0]   div_eff;

    assign tx_wr    = wr_en && (addr == A_TX);
    assign rx_pop   = rd_en && (addr == A_RX);
    assign stat_rd  = rd_en && (addr == A_STAT);
    assign thr_hit  = 8'(rx_cnt) > q.thr;
    assign status   = {thr_hit, q.err[E_BRK], q.err[E_FRM], q.err[E_OVR], q.err[E_PAR],
                       rx_full, !rx_empty, tx_full, tx_empty};
    assign ien      = q.ien;
    assign ovr_flag = q.err[E_OVR];
    assign irq      = |(status & q.ien);
    assign div_eff  = (q.div == 16'd0) ? 16'd1 : q.div;

    sio_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(wdata), .pop(tx_pop),
        .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    sio_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data), .pop(rx_pop),
        .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    sio_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(q.tick), .cfg(q.cfg), .dly(q.dly),
        .empty(tx_empty), .din(tx_dout), .pop(tx_pop), .txd(txd), .idle(tx_idle));

    sio_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(q.tick), .cfg(q.cfg), .iq(q.iq), .rxd(rxd),
        .push(rx_push), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr), .berr(rx_berr));

    always_comb begin
        case (addr)
            A_DIV:   rdata = {16'd0, q.div};
            A_RX:    rdata = rx_empty ? 32'd0 : rx_dout;
            A_STAT:  rdata = {23'd0, status};
            A_DLY:   rdata = {24'd0, q.dly};
            A_CTRL:  rdata = {21'd0, q.cfg, 1'b0};
            A_IEN:   rdata = {23'd0, q.ien};
            A_IQ:    rdata = {24'd0, q.iq};
            A_THR:   rdata = {24'd0, q.thr};
            default: rdata = 32'd0;
        endcase
    end

    always_comb begin
        d = q;
        // oversampling tick generator
        if (q.bcnt >= div_eff - 16'd1) begin
            d.bcnt = '0;
            d.tick = 1'b1;
        end else begin
            d.bcnt = q.bcnt + 16'd1;
            d.tick = 1'b0;
        end
        if (wr_en) begin
            case (addr)
                A_DIV:  d.div = wdata[15:0];
                A_DLY:  d.dly = wdata[7:0];
                A_CTRL: d.cfg = wdata[10:1];
                A_IEN:  d.ien = wdata[8:0];
                A_IQ:   d.iq  = wdata[7:0];
                A_THR:  d.thr = wdata[7:0];
                default: ;
            endcase
        end
        if (stat_rd) d.err = '0;
        if (rx_push) begin
            if (rx_perr) d.err[E_PAR] = 1'b1;
            if (rx_ferr) d.err[E_FRM] = 1'b1;
            if (rx_berr) d.err[E_BRK] = 1'b1;
            if (rx_full) d.err[E_OVR] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cfg.len  <= 6'd8;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_wr,
    input logic          tx_full,
    input logic          tx_pop,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          rx_push,
    input logic          rx_full,
    input logic          ovr_flag,
    input logic          stat_rd,
    input logic          tx_idle,
    input logic          txd,
    input logic          irq,
    input logic [8:0]    ien
);
    a_r12_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !tx_pop) |=> $stable(tx_cnt));

    a_r7_rx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ovr_flag);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !stat_rd) |=> ovr_flag);

    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 9'd0) |-> !irq);
endmodule

bind sio_uart sio_uart_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_full(tx_full), .tx_pop(tx_pop),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_push(rx_push), .rx_full(rx_full),
    .ovr_flag(ovr_flag), .stat_rd(stat_rd), .tx_idle(tx_idle), .txd(txd),
    .irq(irq), .ien(ien));

// File: tb/sim_sio_uart.sv
module sim_sio_uart;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        txd, irq;
    logic        loop = 1'b0, rx_drv = 1'b1;
    wire         rxd = loop ? txd : rx_drv;

    int n_chk = 0, n_fail = 0, div_c = 1, thr_m = 0;

    // behavioural reference model of the receive side and flags
    logic [31:0] mq[$];
    bit m_perr, m_ovr, m_ferr, m_berr;

    always #(CLK_P/2) clk = ~clk;

    sio_uart u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq(irq));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] mask_of(input int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
    endfunction

    function automatic logic [31:0] ctrl(input int len, input int par, input int stp);
        return 32'((len << 5) | (par << 3) | (stp << 1));
    endfunction

    function automatic logic [31:0] exp_status();
        int n = mq.size();
        return {23'd0, (n > thr_m), m_berr, m_ferr, m_ovr, m_perr, (n == 16), (n != 0), 1'b0, 1'b1};
    endfunction

    task automatic set_div(input int v);
        wr(6'h00, 32'(v)); div_c = v;
    endtask

    task automatic set_thr(input int v);
        wr(6'h20, 32'(v)); thr_m = v;
    endtask

    task automatic stat_chk(input string req);
        logic [31:0] v;
        rd(6'h0C, v);
        chk(req, v, exp_status());
        m_perr = 0; m_ovr = 0; m_ferr = 0; m_berr = 0;
    endtask

    task automatic rx_chk(input string req);
        logic [31:0] v, e;
        rd(6'h08, v);
        e = (mq.size() != 0) ? mq.pop_front() : 32'd0;
        chk(req, v, e);
    endtask

    // drive one serial frame into rxd and update the model
    task automatic send_frame(input logic [31:0] dv, input int len, input int pm,
                              input bit flip, input bit stopv);
        int bt = 16 * div_c;
        logic [31:0] dm = dv & mask_of(len);
        bit pb = (pm == 1) ? ~^dm : ^dm;
        rx_drv = 1'b0; step(bt);
        for (int k = 0; k < len; k++) begin rx_drv = dm[k]; step(bt); end
        if (pm != 0) begin rx_drv = pb ^ flip; step(bt); end
        rx_drv = stopv; step(bt);
        rx_drv = 1'b1; step(bt);
        if (mq.size() < 16) mq.push_back(dm); else m_ovr = 1;
        if (pm != 0 && flip) m_perr = 1;
        if (!stopv) m_ferr = 1;
        if (!stopv && dm == 0) m_berr = 1;
    endtask

    // decode one frame on txd by mid-bit sampling
    task automatic tx_decode(input int len, input bit hasp, output logic [31:0] v,
                             output bit p, output bit stp);
        int guard = 0;
        v = '0; p = 0;
        while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
        step(8 * div_c);
        for (int k = 0; k < len; k++) begin step(16 * div_c); v[k] = txd; end
        if (hasp) begin step(16 * div_c); p = txd; end
        step(16 * div_c); stp = txd;
    endtask

    task automatic stop_gap(input int code, input int ticks, input string req);
        int cnt = 0;
        wr(6'h14, ctrl(8, 0, code));
        wr(6'h04, 32'h55); wr(6'h04, 32'h55);
        while (txd !== 1'b0) @(negedge clk);
        step(8 * div_c + 16 * div_c * 8);
        while (txd === 1'b0) @(negedge clk);
        while (txd === 1'b1 && cnt < 1000) begin @(negedge clk); cnt++; end
        chk_rng(req, cnt, ticks * div_c, ticks * div_c + 3);
        step(16 * div_c * 14);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit p, s;
        int cnt;
        step(3); rst_n = 1'b1; step(2);

        // R1: reset state
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        stat_chk("R1 status");

        // R2/R3: 8N1 frame at divisor 2, LSB first
        set_div(2);
        wr(6'h04, 32'hA5);
        tx_decode(8, 0, v, p, s);
        chk("R3 data lsb first", v, 32'hA5);
        chk("R3 stop high", {31'd0, s}, 32'd1);
        step(64);

        // R2: divisor 3 changes bit length, decode still aligns
        set_div(3);
        wr(6'h04, 32'h3C);
        tx_decode(8, 0, v, p, s);
        chk("R2 div3 data", v, 32'h3C);
        step(96);
        set_div(2);

        // R3/R4: 5-bit even parity, high bits dropped
        wr(6'h14, ctrl(5, 2, 0));
        wr(6'h04, 32'h33);
        tx_decode(5, 1, v, p, s);
        chk("R3 len5 data", v, 32'h13);
        chk("R4 even parity bit", {31'd0, p}, 32'd1);
        step(64);

        // R3/R4: 32-bit odd parity loopback
        loop = 1'b1;
        wr(6'h14, ctrl(32, 1, 0));
        wr(6'h04, 32'hDEADBEEF);
        mq.push_back(32'hDEADBEEF);
        step(16 * 2 * 36);
        stat_chk("R4 odd loopback status");
        rx_chk("R3 len32 loopback");
        loop = 1'b0;

        // R5: stop lengths
        stop_gap(0, 16, "R5 one stop");
        stop_gap(1, 24, "R5 one and half stop");
        stop_gap(2, 32, "R5 two stop");
        wr(6'h14, ctrl(8, 0, 0));

        // R6: start delay
        wr(6'h04, 32'h01);
        cnt = 0;
        while (txd === 1'b1 && cnt < 1000) begin @(negedge clk); cnt++; end
        chk_rng("R6 no delay", cnt, 1, 2);
        step(16 * 2 * 11);
        wr(6'h10, 32'd10);
        wr(6'h04, 32'h01);
        cnt = 0;
        while (txd === 1'b1 && cnt < 1000) begin @(negedge clk); cnt++; end
        chk_rng("R6 delay 10", cnt, 9 * 2 + 1, 10 * 2 + 2);
        step(16 * 2 * 11);
        wr(6'h10, 32'd0);

        // R7: receive 8N1
        send_frame(32'h3C, 8, 0, 0, 1);
        stat_chk("R7 rx status");
        rx_chk("R7 rx data");
        rx_chk("R7 empty read");

        // R4/R8/R11: parity error, sticky until status read, irq
        set_thr(255);
        wr(6'h18, 32'h010);
        wr(6'h14, ctrl(8, 2, 0));
        send_frame(32'h01, 8, 2, 1, 1);
        chk("R11 irq on parity err", {31'd0, irq}, 32'd1);
        stat_chk("R4 parity error flag");
        chk("R11 irq after clear", {31'd0, irq}, 32'd0);
        stat_chk("R8 sticky cleared");
        rx_chk("R4 data kept");
        wr(6'h18, 32'h000);
        wr(6'h14, ctrl(8, 0, 0));

        // R8: frame error and break
        send_frame(32'h81, 8, 0, 0, 0);
        stat_chk("R8 frame error");
        rx_chk("R8 frame data");
        send_frame(32'h00, 8, 0, 0, 0);
        stat_chk("R8 break");
        rx_chk("R8 break data");

        // R9: input qualification rejects short pulse
        wr(6'h1C, 32'd5);
        rx_drv = 1'b0; step(3); rx_drv = 1'b1;
        step(16 * 2 * 12);
        stat_chk("R9 glitch ignored");
        send_frame(32'h5A, 8, 0, 0, 1);
        rx_chk("R9 filtered frame");
        wr(6'h1C, 32'd0);

        // R10/R11: threshold flag and interrupt
        set_thr(2);
        wr(6'h18, 32'h100);
        send_frame(32'h11, 8, 0, 0, 1);
        send_frame(32'h22, 8, 0, 0, 1);
        chk("R10 irq at level 2", {31'd0, irq}, 32'd0);
        stat_chk("R10 level 2 status");
        send_frame(32'h33, 8, 0, 0, 1);
        chk("R11 irq above thr", {31'd0, irq}, 32'd1);
        stat_chk("R10 level 3 status");
        rx_chk("R10 pop");
        chk("R11 irq after pop", {31'd0, irq}, 32'd0);
        rx_chk("R10 drain a");
        rx_chk("R10 drain b");
        wr(6'h18, 32'h000);
        set_thr(255);

        // R8/R7: overrun with 17 characters
        for (int i = 0; i < 17; i++) send_frame(32'(i + 8'h40), 8, 0, 0, 1);
        stat_chk("R8 overrun and full");
        for (int i = 0; i < 16; i++) rx_chk("R7 fifo order");
        stat_chk("R7 drained");

        // R12: transmit FIFO full, extra write ignored
        fork
            begin
                for (int i = 1; i <= 18; i++) wr(6'h04, 32'(i));
                rd(6'h0C, v);
                chk("R12 tx full flag", {31'd0, v[1]}, 32'd1);
            end
            begin
                for (int i = 1; i <= 17; i++) begin
                    tx_decode(8, 0, v, p, s);
                    chk("R12 tx order", v, 32'(i));
                end
            end
        join
        cnt = 0;
        for (int i = 0; i < 16 * 2 * 20; i++) begin @(negedge clk); if (txd !== 1'b1) cnt++; end
        chk("R12 no extra frame", 32'(cnt), 32'd0);
        stat_chk("R12 tx empty again");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule